// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits behind the serial command decoder of a small byte-addressed nonvolatile memory. When the decoder has received a WRITE opcode and its address, it raises a start strobe. The block then collects the data bytes that follow into a one-page staging buffer. A page is 16 bytes, selected by the address bits above the low four. When chip select goes high, the block decides from the bit alignment of that edge whether the transaction commits.

A committed transaction starts a modelled programming cycle. During that cycle the busy flag is high and array reads are refused. The staged bytes are pushed to the array one offset per clock. At the end of the cycle the write enable latch is cleared. A parameterised counter stands in for the real programming time. The latch itself lives here and is set or cleared by strobes from the command decoder. A write-protect input refuses new transactions.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `wip_o`, `wel_o`, `rd_inhibit_o` and `arr_we_o` are all 0.
- R2: While not busy, a one-cycle `wel_set_i` pulse makes `wel_o` 1 from the next cycle, and a `wel_clr_i` pulse makes it 0 (clear wins if both are high).
- R3: A `wr_start_i` pulse is refused when `wel_o` is 0 or `wprot_i` is 1. The bytes and chip-select rise that follow then cause no busy cycle and no array write, and leave `wel_o` unchanged.
- R4: The byte offset within the page starts at `start_addr_i[3:0]` and advances by one per accepted byte. Each array write drives `arr_addr_o` = {`start_addr_i[9:4]`, offset} with the last byte loaded at that offset.
- R5: The offset wraps from 15 to 0 inside the same page and never changes the page bits. A byte loaded again at an offset replaces the earlier one.
- R6: A chip-select rise with `cs_aligned_i` = 0 aborts the transaction: no busy cycle, no array write, and `wel_o` keeps its value.
- R7: A chip-select rise with `cs_aligned_i` = 1 but no byte accepted since the start starts no cycle and leaves `wel_o` unchanged.
- R8: A commit (aligned rise after at least one byte) makes `wip_o` 1 from the cycle after the rise. It holds it 1 for exactly max(`PROG_CYCLES`, 16) clocks.
- R9: During the busy window exactly one array write is issued for each loaded offset and none for unloaded offsets. The writes come in ascending offset order and `arr_we_o` is never 1 outside the busy window.
- R10: `wel_o` stays at 1 throughout the busy window and becomes 0 on the clock that ends it. Latch strobes and `wr_start_i` are ignored while busy.
- R11: `rd_inhibit_o` equals `wip_o` in every cycle. The status outputs `wip_o` and `wel_o` remain valid throughout the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Set write enable latch (one cycle) |
| wel_clr_i | input | 1 | Clear write enable latch (one cycle) |
| wprot_i | input | 1 | Write protect, refuses new transactions |
| wr_start_i | input | 1 | WRITE opcode and address received |
| start_addr_i | input | ADDR_W | Start byte address of the transaction |
| byte_vld_i | input | 1 | One complete data byte received |
| byte_i | input | DATA_W | Data byte |
| cs_rise_i | input | 1 | Chip select went high |
| cs_aligned_i | input | 1 | Bit count was on a byte boundary at that rise |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| wip_o | output | 1 | Write cycle in progress |
| wel_o | output | 1 | Write enable latch |
| rd_inhibit_o | output | 1 | Array reads refused |

## Verification
Suppose the in-page offset counter or the loaded mask is wrong. The writes then show up with a wrong address, a missing or extra offset, or stale data. All of this is visible within the first sixteen clocks of the busy window. A commit decision that is wrong shows at the ports the very next cycle, as `wip_o` rising or failing to rise. The cycle timer is observed through the exact length of `wip_o` and through the clock on which `wel_o` drops. The latch gating is observed through whether a transaction started at all.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
// One-page staging store: a register per byte slot plus a loaded mask.
module pw_page_buf #(
  parameter int PAGE_AW = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [PAGE_AW-1:0] wr_off_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [PAGE_AW-1:0] rd_off_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_loaded_o
);
  localparam int DEPTH = 1 << PAGE_AW;

  logic [DEPTH-1:0][DATA_W-1:0] slots;
  logic [DEPTH-1:0]             ld_q, ld_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] slot_q;
    assign hit = wr_en_i && (wr_off_i == PAGE_AW'(gi));
    // data slots need no reset: the loaded mask qualifies them
    always_ff @(posedge clk) begin
      if (hit) slot_q <= wr_data_i;
    end
    assign slots[gi] = slot_q;
  end

  always_comb begin
    ld_d = ld_q;
    if (clr_i)        ld_d = '0;
    else if (wr_en_i) ld_d[wr_off_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= '0;
    else        ld_q <= ld_d;
  end

  assign rd_data_o   = slots[rd_off_i];
  assign rd_loaded_o = ld_q[rd_off_i];
endmodule

// File: rtl/pw_busy_timer.sv
// Models the programming time and sweeps the page offsets at its start.
module pw_busy_timer #(
  parameter int CYCLES  = 40,
  parameter int PAGE_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic               last_o,
  output logic               scan_vld_o,
  output logic [PAGE_AW-1:0] scan_off_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int EFF        = (CYCLES < PAGE_BYTES) ? PAGE_BYTES : CYCLES;
  localparam int CNT_W      = $clog2(EFF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EFF - 1);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last_o = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (last_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o     = busy_q;
  assign scan_vld_o = busy_q && (cnt_q < SWEEP_END);
  assign scan_off_o = cnt_q[PAGE_AW-1:0];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_AW     = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              wprot_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              wip_o,
  output logic              wel_o,
  output logic              rd_inhibit_o
);
  localparam int PG_W = ADDR_W - PAGE_AW;

  pw_state_e          state_q, state_d;
  logic [PG_W-1:0]    page_q;
  logic [PAGE_AW-1:0] off_q, off_d;
  logic               off_en;
  logic               got_q, got_d;
  logic               wel_q, wel_d;

  logic accept, take_byte, commit, abort;
  logic tmr_busy, tmr_last, scan_vld, slot_loaded;
  logic [PAGE_AW-1:0] scan_off;
  logic [DATA_W-1:0]  slot_data;

  // transaction decisions
  assign accept    = (state_q == PW_IDLE) && wr_start_i && wel_q && !wprot_i;
  assign take_byte = (state_q == PW_LOAD) && byte_vld_i;
  assign commit    = (state_q == PW_LOAD) && cs_rise_i && cs_aligned_i && got_q;
  assign abort     = (state_q == PW_LOAD) && cs_rise_i && !commit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_IDLE: if (accept) state_d = PW_LOAD;
      PW_LOAD: begin
        if (commit)     state_d = PW_PROG;
        else if (abort) state_d = PW_IDLE;
      end
      PW_PROG: if (tmr_last) state_d = PW_IDLE;
      default: state_d = PW_IDLE;
    endcase
  end

  always_comb begin
    off_en = accept || take_byte;
    off_d  = accept ? start_addr_i[PAGE_AW-1:0] : off_q + PAGE_AW'(1);
    got_d  = got_q;
    if (accept)         got_d = 1'b0;
    else if (take_byte) got_d = 1'b1;
  end

  always_comb begin
    wel_d = wel_q;
    if (tmr_last)                 wel_d = 1'b0;
    else if (state_q != PW_PROG) begin
      if (wel_clr_i)              wel_d = 1'b0;
      else if (wel_set_i)         wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      got_q   <= 1'b0;
      wel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) page_q <= start_addr_i[ADDR_W-1:PAGE_AW];
      if (off_en) off_q  <= off_d;
      got_q <= got_d;
      wel_q <= wel_d;
    end
  end

  pw_page_buf #(
    .PAGE_AW (PAGE_AW),
    .DATA_W  (DATA_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (accept),
    .wr_en_i     (take_byte),
    .wr_off_i    (off_q),
    .wr_data_i   (byte_i),
    .rd_off_i    (scan_off),
    .rd_data_o   (slot_data),
    .rd_loaded_o (slot_loaded)
  );

  pw_busy_timer #(
    .CYCLES  (PROG_CYCLES),
    .PAGE_AW (PAGE_AW)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (commit),
    .busy_o     (tmr_busy),
    .last_o     (tmr_last),
    .scan_vld_o (scan_vld),
    .scan_off_o (scan_off)
  );

  assign arr_we_o     = scan_vld && slot_loaded;
  assign arr_addr_o   = {page_q, scan_off};
  assign arr_data_o   = slot_data;
  assign wip_o        = (state_q == PW_PROG);
  assign wel_o        = wel_q;
  assign rd_inhibit_o = tmr_busy;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int ADDR_W  = 10,
  parameter int PAGE_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise_i,
  input logic              cs_aligned_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              wip_o,
  input logic              wel_o,
  input logic              rd_inhibit_o
);
  a_r11_inhibit_tracks_wip: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inhibit_o == wip_o);

  a_r8_rise_needs_aligned_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(cs_rise_i && cs_aligned_i));

  a_r3_rise_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> wel_o);

  a_r6_misaligned_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !cs_aligned_i && !wip_o) |=> !wip_o);

  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> wip_o);

  a_r9_ascending_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[PAGE_AW-1:0] > $past(arr_addr_o[PAGE_AW-1:0])));

  a_r5_page_constant: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[ADDR_W-1:PAGE_AW] == $past(arr_addr_o[ADDR_W-1:PAGE_AW])));

  a_r10_wel_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_o) |-> !wel_o);

  a_r10_wel_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_o && $past(wip_o)) |-> $stable(wel_o));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W  (ADDR_W),
  .PAGE_AW (PAGE_AW)
) u_chk (.*);

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int PROG   = 40;
  localparam int BUSY   = (PROG < 16) ? 16 : PROG;

  typedef struct packed {
    logic       wel;
    logic       prot;
    logic [9:0] addr;
    logic [5:0] n;
    logic       al;
    logic       commit;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 10'h000, 6'd1,  1'b1, 1'b1},
    '{1'b1, 1'b0, 10'h05A, 6'd4,  1'b1, 1'b1},
    '{1'b1, 1'b0, 10'h3FC, 6'd6,  1'b1, 1'b1},
    '{1'b1, 1'b0, 10'h120, 6'd20, 1'b1, 1'b1},
    '{1'b1, 1'b0, 10'h200, 6'd3,  1'b0, 1'b0},
    '{1'b1, 1'b0, 10'h210, 6'd0,  1'b1, 1'b0},
    '{1'b0, 1'b0, 10'h300, 6'd2,  1'b1, 1'b0},
    '{1'b1, 1'b1, 10'h300, 6'd2,  1'b1, 1'b0},
    '{1'b1, 1'b0, 10'h0FF, 6'd16, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic wel_set_i, wel_clr_i, wprot_i, wr_start_i, byte_vld_i, cs_rise_i, cs_aligned_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic [7:0] byte_i;
  logic arr_we_o, wip_o, wel_o, rd_inhibit_o;
  logic [ADDR_W-1:0] arr_addr_o;
  logic [7:0] arr_data_o;

  int checks = 0, errors = 0, cyc = 0;
  int wr_n = 0, wip_n = 0, rise_cyc = -1, inh_bad = 0;
  logic prev_wip = 1'b0;
  logic [ADDR_W-1:0] log_addr [512];
  logic [7:0]        log_data [512];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(.ADDR_W(ADDR_W), .PAGE_AW(4), .DATA_W(8), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
    .wprot_i(wprot_i), .wr_start_i(wr_start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .cs_rise_i(cs_rise_i),
    .cs_aligned_i(cs_aligned_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o), .wip_o(wip_o), .wel_o(wel_o), .rd_inhibit_o(rd_inhibit_o));

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we_o && wr_n < 512) begin
        log_addr[wr_n] = arr_addr_o;
        log_data[wr_n] = arr_data_o;
        wr_n = wr_n + 1;
      end
      if (wip_o) wip_n = wip_n + 1;
      if (wip_o && !prev_wip) rise_cyc = cyc;
      if (rd_inhibit_o !== wip_o) inh_bad = inh_bad + 1;
      prev_wip = wip_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] dat(input int v, input int k);
    return 8'(v * 37 + k * 11 + 5);
  endfunction

  task automatic run_vec(input int v);
    vec_t t = VECS[v];
    int base_w, base_wip, cs_cyc, nexp, idx;
    logic [7:0] img [16];
    bit ld [16];
    for (int i = 0; i < 16; i++) begin img[i] = 8'h00; ld[i] = 0; end
    if (t.wel) wel_set_i = 1'b1; else wel_clr_i = 1'b1;
    tick();
    wel_set_i = 1'b0; wel_clr_i = 1'b0;
    wprot_i = t.prot;
    wr_start_i = 1'b1; start_addr_i = t.addr;
    tick();
    wr_start_i = 1'b0;
    base_w = wr_n; base_wip = wip_n;
    for (int k = 0; k < int'(t.n); k++) begin
      byte_vld_i = 1'b1; byte_i = dat(v, k);
      tick();
      byte_vld_i = 1'b0;
      if (k % 2 == 1) tick();
      img[(int'(t.addr) + k) % 16] = dat(v, k);
      ld[(int'(t.addr) + k) % 16] = 1;
    end
    cs_rise_i = 1'b1; cs_aligned_i = t.al; cs_cyc = cyc;
    tick();
    cs_rise_i = 1'b0; cs_aligned_i = 1'b0; wprot_i = 1'b0;
    repeat (BUSY + 4) tick();
    // R8 busy length and start cycle; R3 R6 R7 no cycle when refused
    chk((wip_n - base_wip) == (t.commit ? BUSY : 0), $sformatf("R8 R3 R6 R7 busy length vec%0d", v),
        wip_n - base_wip, t.commit ? BUSY : 0);
    if (t.commit)
      chk(rise_cyc == cs_cyc + 1, $sformatf("R8 busy start cycle vec%0d", v), rise_cyc, cs_cyc + 1);
    nexp = 0;
    if (t.commit) for (int i = 0; i < 16; i++) if (ld[i]) nexp++;
    chk((wr_n - base_w) == nexp, $sformatf("R9 write count vec%0d", v), wr_n - base_w, nexp);
    if ((wr_n - base_w) == nexp) begin
      idx = base_w;
      for (int i = 0; i < 16; i++) begin
        if (t.commit && ld[i]) begin
          chk(log_addr[idx] == {t.addr[9:4], 4'(i)}, $sformatf("R4 R5 R9 address vec%0d", v),
              int'(log_addr[idx]), int'({t.addr[9:4], 4'(i)}));
          chk(log_data[idx] == img[i], $sformatf("R4 R5 data vec%0d off%0d", v, i),
              int'(log_data[idx]), int'(img[i]));
          idx++;
        end
      end
    end
    chk(wel_o == (t.commit ? 1'b0 : t.wel), $sformatf("R10 R3 R6 R7 latch after vec%0d", v),
        int'(wel_o), int'(t.commit ? 1'b0 : t.wel));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base_wip, base_w;
    rst_n = 1'b0;
    wel_set_i = 0; wel_clr_i = 0; wprot_i = 0; wr_start_i = 0; start_addr_i = '0;
    byte_vld_i = 0; byte_i = '0; cs_rise_i = 0; cs_aligned_i = 0;
    repeat (3) tick();
    // R1 reset state
    chk(wip_o == 0 && wel_o == 0 && rd_inhibit_o == 0 && arr_we_o == 0, "R1 reset outputs",
        int'({wip_o, wel_o, rd_inhibit_o, arr_we_o}), 0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) run_vec(v);

    // R2 latch set and clear while idle
    wel_set_i = 1'b1; tick(); wel_set_i = 1'b0; tick();
    chk(wel_o == 1'b1, "R2 latch set", int'(wel_o), 1);
    wel_clr_i = 1'b1; wel_set_i = 1'b1; tick(); wel_clr_i = 1'b0; wel_set_i = 1'b0; tick();
    chk(wel_o == 1'b0, "R2 clear wins", int'(wel_o), 0);

    // R10 R11 strobes ignored while busy
    wel_set_i = 1'b1; tick(); wel_set_i = 1'b0;
    wr_start_i = 1'b1; start_addr_i = 10'h080; tick(); wr_start_i = 1'b0;
    byte_vld_i = 1'b1; byte_i = 8'hA5; tick(); byte_vld_i = 1'b0;
    cs_rise_i = 1'b1; cs_aligned_i = 1'b1; tick(); cs_rise_i = 1'b0; cs_aligned_i = 1'b0;
    repeat (5) tick();
    wel_clr_i = 1'b1; tick(); wel_clr_i = 1'b0; tick();
    chk(wel_o == 1'b1, "R10 clear ignored while busy", int'(wel_o), 1);
    chk(wip_o == 1'b1 && rd_inhibit_o == 1'b1, "R11 reads refused while busy",
        int'({wip_o, rd_inhibit_o}), 3);
    wr_start_i = 1'b1; start_addr_i = 10'h090; tick(); wr_start_i = 1'b0;
    byte_vld_i = 1'b1; byte_i = 8'h3C; tick(); byte_vld_i = 1'b0;
    repeat (BUSY) tick();
    chk(wel_o == 1'b0 && wip_o == 1'b0, "R10 latch cleared after cycle", int'({wel_o, wip_o}), 0);
    base_wip = wip_n; base_w = wr_n;
    cs_rise_i = 1'b1; cs_aligned_i = 1'b1; tick(); cs_rise_i = 1'b0; cs_aligned_i = 1'b0;
    repeat (BUSY + 4) tick();
    chk(wip_n == base_wip && wr_n == base_w, "R10 start during busy ignored",
        wip_n - base_wip, 0);
    chk(inh_bad == 0, "R11 inhibit mismatches", inh_bad, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule